// File: doc/BRIEF.md
# Burst Column Address Generator

This block steps a memory column address through one burst. A start strobe loads a start column together with the mode word: a length code, an ordering bit and a bit that forces single-beat writes. From the next cycle on, the block presents one column per beat. It moves to the next beat on each cycle where the advance enable is high. Every fixed-length burst stays inside the aligned block that the upper column bits select, and it wraps back to the start of that block. A full-page burst walks the whole row. It wraps from the top column to column 0 and runs until a terminate strobe or a new start ends it.

The block is built around a three-state machine. `ST_IDLE` presents nothing. `ST_FIXED` runs a burst of 1, 2, 4 or 8 beats. `ST_PAGE` runs an endless full-page burst. The transitions are:

- start: from any state to `ST_FIXED` or `ST_PAGE`, chosen by the decoded length.
- finish: from `ST_FIXED` to `ST_IDLE` when the final beat is advanced.
- terminate: from `ST_FIXED` or `ST_PAGE` to `ST_IDLE`.
- step: stay in the current burst state and move to the next beat.
- hold: stay on the same beat when advance is low.

A start in the same cycle as a terminate wins. The mode word is captured at the start strobe.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is held and after it, `col_valid` and `col_last` are 0.
- R2: A start strobe makes `col_valid` 1 in the next cycle, with `col` equal to the start column.
- R3: With a length of 8 (code 3'b011) and the ordering bit 0, the beats count up from the start column inside the aligned group of 8 columns (bits 7:3 fixed) and wrap to the bottom of that group. Start 0x2D gives 2D,2E,2F,28,29,2A,2B,2C.
- R4: With the ordering bit 1, each beat is the block base ORed with (start offset XOR beat index). Length 8 from 0x2D gives 2D,2C,2F,2E,29,28,2B,2A.
- R5: `col_last` is 1 only on the final beat of a fixed-length burst. Advancing past that beat makes `col_valid` 0 in the next cycle.
- R6: Code 3'b000 and the reserved codes 3'b100, 3'b101 and 3'b110 give one beat at the start column, whatever the ordering bit is.
- R7: Code 3'b111 (full page) always counts sequentially, also when the ordering bit is 1. It wraps from 0xFF to 0x00 and never raises `col_last`.
- R8: A terminate strobe without a start makes `col_valid` 0 in the next cycle.
- R9: When the single-write bit is 1, a write start gives exactly one beat. A read start keeps the programmed length.
- R10: A start during a burst abandons the burst. The next cycle presents the new start column, and the new burst runs from there.
- R11: While `advance` is 0 and neither strobe is present, `col` and `col_valid` hold their values.
- R12: Length 2 (code 3'b001) wraps inside bits 7:1, and length 4 (code 3'b010) wraps inside bits 7:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_len | input | 3 | Burst length code |
| mode_ileave | input | 1 | 1 selects interleaved order |
| mode_wr_single | input | 1 | 1 makes every write one beat |
| start | input | 1 | Begin a burst (truncates any running one) |
| start_wr | input | 1 | The starting access is a write |
| start_col | input | COL_W | Start column |
| term | input | 1 | End the running burst |
| advance | input | 1 | Step to the next beat |
| col | output | COL_W | Current beat column |
| col_valid | output | 1 | A beat is presented |
| col_last | output | 1 | Current beat is the final one |

## Verification
The bench builds the block with its default column width of 8. At that width the full page spans 256 columns, so the wrap from 0xFF to 0x00 is reached in a few beats from a start near the top. The same width also gives the aligned groups of 2, 4 and 8 with their distinct wrap points. Those wraps are exercised by starts placed just below a group boundary, in both orderings, together with truncation, holds and single-beat writes.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
    localparam int LEN_CODE_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIXED = 2'd1,
        ST_PAGE  = 2'd2
    } bstate_t;

    localparam logic [LEN_CODE_W-1:0] LC_ONE   = 3'b000;
    localparam logic [LEN_CODE_W-1:0] LC_TWO   = 3'b001;
    localparam logic [LEN_CODE_W-1:0] LC_FOUR  = 3'b010;
    localparam logic [LEN_CODE_W-1:0] LC_EIGHT = 3'b011;
    localparam logic [LEN_CODE_W-1:0] LC_PAGE  = 3'b111;
endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
    import burst_col_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [LEN_CODE_W-1:0] len_code,
    input  logic                  wr_single,
    input  logic                  is_write,
    output logic [COL_W-1:0]      blk_mask,
    output logic                  full_page
);
    logic force_one;

    always_comb begin
        force_one = wr_single && is_write;
        full_page = 1'b0;
        blk_mask  = '0;
        if (!force_one) begin
            unique case (len_code)
                LC_TWO:   blk_mask = COL_W'(1);
                LC_FOUR:  blk_mask = COL_W'(3);
                LC_EIGHT: blk_mask = COL_W'(7);
                LC_PAGE: begin
                    blk_mask  = '1;
                    full_page = 1'b1;
                end
                default:  blk_mask = '0;
            endcase
        end
    end
endmodule

// File: rtl/burst_beat_gen.sv
module burst_beat_gen #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] offset,
    input  logic [COL_W-1:0] beat,
    input  logic [COL_W-1:0] mask,
    input  logic             ileave,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] seq_off;
    logic [COL_W-1:0] ilv_off;

    always_comb begin
        seq_off = (offset + beat) & mask;
        ilv_off = (offset ^ beat) & mask;
        col     = base | (ileave ? ilv_off : seq_off);
    end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import burst_col_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [LEN_CODE_W-1:0] mode_len,
    input  logic                  mode_ileave,
    input  logic                  mode_wr_single,
    input  logic                  start,
    input  logic                  start_wr,
    input  logic [COL_W-1:0]      start_col,
    input  logic                  term,
    input  logic                  advance,
    output logic [COL_W-1:0]      col,
    output logic                  col_valid,
    output logic                  col_last
);
    bstate_t          state_q, state_d;
    logic [COL_W-1:0] base_q, off_q, beat_q, mask_q;
    logic             ilv_q;
    logic [COL_W-1:0] mask_d;
    logic             page_d;
    logic             at_final;

    burst_len_decode #(.COL_W(COL_W)) u_dec (
        .len_code (mode_len),
        .wr_single(mode_wr_single),
        .is_write (start_wr),
        .blk_mask (mask_d),
        .full_page(page_d)
    );

    burst_beat_gen #(.COL_W(COL_W)) u_beat (
        .base  (base_q),
        .offset(off_q),
        .beat  (beat_q),
        .mask  (mask_q),
        .ileave(ilv_q),
        .col   (col)
    );

    assign at_final = (state_q == ST_FIXED) && (beat_q == mask_q);

    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = page_d ? ST_PAGE : ST_FIXED;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_FIXED: begin
                    if (term)                      state_d = ST_IDLE;
                    else if (advance && at_final)  state_d = ST_IDLE;
                end
                ST_PAGE: begin
                    if (term) state_d = ST_IDLE;
                end
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            off_q   <= '0;
            beat_q  <= '0;
            mask_q  <= '0;
            ilv_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start) begin
                base_q <= start_col & ~mask_d;
                off_q  <= start_col & mask_d;
                beat_q <= '0;
                mask_q <= mask_d;
                ilv_q  <= mode_ileave && !page_d;
            end else if (advance && state_q != ST_IDLE) begin
                beat_q <= (beat_q + COL_W'(1)) & mask_q;
            end
        end
    end

    always_comb begin
        col_valid = 1'b0;
        col_last  = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_FIXED: begin
                col_valid = 1'b1;
                col_last  = at_final;
            end
            ST_PAGE:  col_valid = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [COL_W-1:0] start_col,
    input logic             term,
    input logic             advance,
    input logic [COL_W-1:0] col,
    input logic             col_valid,
    input logic             col_last
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> !col_valid && !col_last);

    assert_start_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> col_valid && col == $past(start_col));

    assert_last_needs_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        col_last |-> col_valid);

    assert_last_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        col_last && advance && !start && !term |=> !col_valid);

    assert_term_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        term && !start |=> !col_valid);

    assert_hold_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid && !advance && !start && !term |=> col_valid && $stable(col));
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .start_col(start_col),
    .term     (term),
    .advance  (advance),
    .col      (col),
    .col_valid(col_valid),
    .col_last (col_last)
);

// File: tb/burst_col_gen_bench.sv
module burst_col_gen_bench;
    localparam int COL_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       mode_len = '0;
    logic             mode_ileave = 1'b0;
    logic             mode_wr_single = 1'b0;
    logic             start = 1'b0;
    logic             start_wr = 1'b0;
    logic [COL_W-1:0] start_col = '0;
    logic             term = 1'b0;
    logic             advance = 1'b0;
    logic [COL_W-1:0] col;
    logic             col_valid;
    logic             col_last;

    int checks = 0;
    int errors = 0;
    bit mon_on = 1'b0;

    typedef struct {
        logic [COL_W-1:0] c;
        logic             last;
        string            tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    burst_col_gen #(.COL_W(COL_W)) u_burst_col_gen (
        .clk(clk), .rst_n(rst_n), .mode_len(mode_len), .mode_ileave(mode_ileave),
        .mode_wr_single(mode_wr_single), .start(start), .start_wr(start_wr),
        .start_col(start_col), .term(term), .advance(advance),
        .col(col), .col_valid(col_valid), .col_last(col_last)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // monitor: compares each presented beat against the scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (mon_on && rst_n && col_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "unexpected beat", int'(col), 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(col == e.c, e.tag, int'(col), int'(e.c));
                    check(col_last == e.last, {e.tag, " last"}, int'(col_last), int'(e.last));
                end
            end
        end
    end

    // expected beats per the requirements
    function automatic int beats_of(input logic [2:0] code, input bit ws, input bit wr);
        if (ws && wr) return 1;
        case (code)
            3'b001: return 2;
            3'b010: return 4;
            3'b011: return 8;
            3'b111: return 0;
            default: return 1;
        endcase
    endfunction

    // fin: 0 natural end, 1 terminate, 2 leave running for a restart
    task automatic do_burst(input logic [2:0] code, input bit il, input bit ws, input bit wr,
                            input logic [COL_W-1:0] scol, input int npush, input int fin,
                            input string tag);
        int L;
        bit page;
        L = beats_of(code, ws, wr);
        page = (L == 0);
        if (page) L = 256;
        for (int k = 0; k < npush; k++) begin
            exp_t e;
            int m, off, base;
            m = L - 1;
            off = scol & m;
            base = scol & ~m;
            if (il && !page) e.c = COL_W'(base | ((off ^ k) & m));
            else             e.c = COL_W'(base | ((off + k) & m));
            e.last = !page && (k == L - 1);
            e.tag = tag;
            sb.push_back(e);
        end
        mode_len = code; mode_ileave = il; mode_wr_single = ws;
        start_wr = wr; start_col = scol; start = 1'b1; advance = 1'b1; term = 1'b0;
        for (int i = 1; i <= npush; i++) begin
            @(negedge clk);
            if (i == 1) start = 1'b0;
        end
        if (fin == 1) begin
            term = 1'b1;
            @(negedge clk);
            term = 1'b0;
            check(!col_valid, {tag, " R8 terminate"}, int'(col_valid), 0);
        end else if (fin == 0) begin
            @(negedge clk);
            check(!col_valid, {tag, " R5 end"}, int'(col_valid), 0);
        end
        if (fin != 2) check(sb.size() == 0, {tag, " beats left"}, sb.size(), 0);
    endtask

    initial begin
        #2_000_000;
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!col_valid && !col_last, "R1 in reset", int'(col_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!col_valid && !col_last, "R1 after reset", int'(col_valid), 0);
        mon_on = 1'b1;

        do_burst(3'b011, 0, 0, 0, 8'h2D, 8, 0, "R3 seq8");     // 2D 2E 2F 28..2C
        do_burst(3'b011, 1, 0, 0, 8'h2D, 8, 0, "R4 ilv8");     // 2D 2C 2F 2E 29 28 2B 2A
        do_burst(3'b000, 1, 0, 0, 8'h37, 1, 0, "R6 len1");
        do_burst(3'b101, 1, 0, 0, 8'h4A, 1, 0, "R6 reserved");
        do_burst(3'b110, 0, 0, 0, 8'h81, 1, 0, "R6 reserved");
        do_burst(3'b111, 1, 0, 0, 8'hFD, 6, 1, "R7 page");     // FD FE FF 00 01 02
        do_burst(3'b011, 0, 1, 1, 8'h53, 1, 0, "R9 wr single");
        do_burst(3'b011, 0, 1, 0, 8'h53, 8, 0, "R9 rd keeps len");
        do_burst(3'b001, 0, 0, 0, 8'h0B, 2, 0, "R12 len2");    // 0B 0A
        do_burst(3'b010, 0, 0, 0, 8'h0E, 4, 0, "R12 len4");    // 0E 0F 0C 0D
        do_burst(3'b010, 1, 0, 0, 8'h0D, 4, 0, "R12 ilv4");    // 0D 0C 0F 0E
        do_burst(3'b011, 0, 0, 0, 8'h10, 3, 2, "R10 cut");
        do_burst(3'b010, 0, 0, 0, 8'h66, 4, 0, "R10 restart");
        do_burst(3'b011, 0, 0, 0, 8'h90, 4, 1, "R8 fixed term");

        // R11 hold: advance low keeps the beat
        mon_on = 1'b0;
        mode_len = 3'b010; mode_ileave = 0; mode_wr_single = 0; start_wr = 0;
        start_col = 8'h10; start = 1'b1; advance = 1'b0;
        @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        check(col_valid && col == 8'h10, "R11 hold", int'(col), 'h10);
        advance = 1'b1;
        @(negedge clk); advance = 1'b0;
        check(col_valid && col == 8'h11, "R11 step", int'(col), 'h11);
        @(negedge clk);
        check(col == 8'h11 && !col_last, "R11 hold again", int'(col), 'h11);
        term = 1'b1;
        @(negedge clk); term = 1'b0;
        check(!col_valid, "R8 term on hold", int'(col_valid), 0);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule